// File: doc/BRIEF.md
# Snapshot Position Byte Reader

This block lets a host read a 16-bit position count over an 8-bit data bus as two successive bytes, both taken from the same value. A position latch copies the running count on every rising clock edge. An inhibit state machine runs on the falling clock edge and samples the active-low output enable and the byte-select input. A high-byte read freezes the latch. The freeze lasts until the low byte has been read and the enable has gone inactive again. The counter outside the block keeps counting while the latch is frozen, so no counts are lost during a read.

The selected byte appears on an 8-bit data output. A separate enable output is the inverse of the bus enable and drives an external tri-state buffer. The data output reads as zero whenever that enable is inactive.

Top module: `pos_read_if`

## Requirements
- R1: While not inhibited, the latch loads `count_i` on every rising edge of `clk_i`, so the bytes shown come from the count present at the most recent rising edge.
- R2: When the falling edge samples `oe_ni` = 0 with `sel_i` = 0, the inhibit is set. From the next rising edge on, the latch no longer loads.
- R3: While inhibited, changes on `count_i` have no effect on the latch. Both bytes of a read come from one snapshot.
- R4: With `oe_ni` = 0, `sel_i` = 0 puts latch bits 15:8 on `data_o`, and `sel_i` = 1 puts latch bits 7:0 on `data_o`.
- R5: `data_oe_o` equals the inverse of `oe_ni`. While `oe_ni` = 1, `data_o` is zero.
- R6: After the low byte has been sampled (`oe_ni` = 0, `sel_i` = 1) during an inhibit, a falling edge that samples `oe_ni` = 1 releases the inhibit. The latch then reloads on the next rising edge.
- R7: A low-byte access (`oe_ni` = 0, `sel_i` = 1) with no high-byte read before it does not set the inhibit. The latch keeps tracking.
- R8: A high-byte access sampled after the low byte, while still inhibited, keeps the inhibit. The same snapshot is read again.
- R9: Sampling `oe_ni` = 1 after the high byte but before the low byte does not release the inhibit.
- R10: An asynchronous low level on `rst_ni` clears the latch to zero and returns the inhibit logic to the released state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the latch loads on the rising edge, the inhibit logic on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Running position count from the counter |
| oe_ni | input | 1 | Active-low bus output enable |
| sel_i | input | 1 | Byte select: 0 high byte, 1 low byte |
| data_o | output | 8 | Selected latch byte, zero when not enabled |
| data_oe_o | output | 1 | Enable for the external tri-state buffer |

## Verification
The bench builds the block with its default 16-bit position and 8-bit byte. At that size every byte value can appear in each half, and a wrong slice or a swapped byte order shows up quickly. Random counts together with random enable and select patterns reach every inhibit state and every transition between them. Directed sequences cover the double high-byte read, the early enable release, the stray low-byte read, and a reset asserted in the middle of a read.

// File: rtl/pos_rd_pkg.sv
package pos_rd_pkg;
  typedef enum logic [1:0] {
    INH_IDLE     = 2'd0,
    INH_HOLD     = 2'd1,
    INH_LOW_DONE = 2'd2
  } inh_state_e;
endpackage

// File: rtl/pos_rd_inhibit.sv
module pos_rd_inhibit
  import pos_rd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic sel_i,
  output logic inhibit_o
);
  inh_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      INH_IDLE:     if (!oe_ni && !sel_i) state_d = INH_HOLD;
      INH_HOLD:     if (!oe_ni && sel_i)  state_d = INH_LOW_DONE;
      INH_LOW_DONE: begin
        if (oe_ni)       state_d = INH_IDLE;
        else if (!sel_i) state_d = INH_HOLD;
      end
      default:      state_d = INH_IDLE;
    endcase
  end

  // falling-edge sampling of the bus strobes
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= INH_IDLE;
    else         state_q <= state_d;
  end

  assign inhibit_o = (state_q != INH_IDLE);

  a_r2_high_read_sets: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !sel_i) |=> inhibit_o);
  a_r6_release_after_low: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (state_q == INH_LOW_DONE && oe_ni) |=> !inhibit_o);
  a_r9_no_early_release: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (state_q == INH_HOLD) |=> inhibit_o);
  a_r7_low_alone_idle: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!inhibit_o && sel_i) |=> !inhibit_o);
endmodule

// File: rtl/pos_rd_latch.sv
module pos_rd_latch #(
  parameter int unsigned POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic [POS_W-1:0] count_i,
  output logic [POS_W-1:0] pos_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pos_o <= '0;
    else if (!inhibit_i) pos_o <= count_i;
  end

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> $stable(pos_o));
  a_r1_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_i |=> (pos_o == $past(count_i)));
endmodule

// File: rtl/pos_rd_mux.sv
module pos_rd_mux #(
  parameter int unsigned POS_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic              oe_ni,
  input  logic              sel_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int unsigned NUM_BYTES = POS_W / BYTE_W;

  logic [BYTE_W-1:0] byte_w [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
    assign byte_w[g] = pos_i[g*BYTE_W +: BYTE_W];
  end

  assign data_oe_o = ~oe_ni;
  // sel 0: most significant byte first, sel 1: least significant
  assign data_o = !data_oe_o ? '0 : (sel_i ? byte_w[0] : byte_w[NUM_BYTES-1]);

  always_comb begin
    a_r5_idle_zero: assert (data_oe_o || data_o == '0);
  end
endmodule

// File: rtl/pos_read_if.sv
module pos_read_if #(
  parameter int unsigned POS_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  count_i,
  input  logic              oe_ni,
  input  logic              sel_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  logic             inhibit;
  logic [POS_W-1:0] pos_q;

  pos_rd_inhibit i_inhibit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oe_ni     (oe_ni),
    .sel_i     (sel_i),
    .inhibit_o (inhibit)
  );

  pos_rd_latch #(.POS_W(POS_W)) i_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inhibit_i (inhibit),
    .count_i   (count_i),
    .pos_o     (pos_q)
  );

  pos_rd_mux #(.POS_W(POS_W), .BYTE_W(BYTE_W)) i_mux (
    .pos_i     (pos_q),
    .oe_ni     (oe_ni),
    .sel_i     (sel_i),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  a_r10_reset_clear: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (pos_q == '0));
endmodule

// File: tb/test_pos_read_if.sv
module test_pos_read_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        oe_n = 1'b1;
  logic        sel = 1'b0;
  logic [7:0]  data;
  logic        data_oe;

  int unsigned checks = 0;
  int unsigned errors = 0;

  always #5 clk = ~clk;

  pos_read_if i_pos_read_if (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .oe_ni(oe_n), .sel_i(sel),
    .data_o(data), .data_oe_o(data_oe)
  );

  // reference model written from the requirements
  // 0 released, 1 high byte taken, 2 low byte taken
  int          m_st = 0;
  logic [15:0] m_pos = '0;

  function automatic int next_st(int st, logic o, logic s);
    if (st == 0) return (!o && !s) ? 1 : 0;
    if (st == 1) return (!o && s) ? 2 : 1;
    if (o) return 0;
    return s ? 2 : 1;
  endfunction

  function automatic logic [7:0] exp_data(logic o, logic s, logic [15:0] p);
    if (o) return 8'h00;
    return s ? p[7:0] : p[15:8];
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_pos <= '0;
    else if (m_st == 0) m_pos <= cnt;

  always @(negedge clk or negedge rst_n)
    if (!rst_n) m_st <= 0;
    else m_st <= next_st(m_st, oe_n, sel);

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(logic o, logic s, logic [15:0] c, string tag);
    string t;
    @(posedge clk);
    #2;
    oe_n = o; sel = s; cnt = c;
    #2;
    t = tag;
    if (t == "") t = o ? "R5" : (m_st != 0) ? "R3" : (s ? "R7" : "R1");
    check("R5", {7'd0, data_oe}, {7'd0, ~o});
    check(t, data, exp_data(o, s, m_pos));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R10: held in reset, latch reads zero
    step(1'b0, 1'b0, 16'hBEEF, "R10");
    step(1'b0, 1'b1, 16'hCAFE, "R10");
    @(posedge clk); #2 rst_n = 1'b1; oe_n = 1'b1;
    // R1 / R5 tracking with bus idle
    step(1'b1, 1'b0, 16'h0102, "R5");
    step(1'b1, 1'b1, 16'h0304, "R5");
    // R7: lone low-byte read keeps tracking
    step(1'b0, 1'b1, 16'h0506, "R7");
    step(1'b0, 1'b1, 16'h0708, "R7");
    step(1'b0, 1'b1, 16'h090A, "R7");
    // R2 / R4: high byte freezes
    step(1'b0, 1'b0, 16'h1234, "R2");
    step(1'b0, 1'b0, 16'h2345, "R4");
    // R9: early enable release keeps snapshot
    step(1'b1, 1'b1, 16'hABCD, "R9");
    step(1'b0, 1'b0, 16'hABCE, "R9");
    // R3 / R4: low byte from the same snapshot
    step(1'b0, 1'b1, 16'h5555, "R3");
    // R8: high byte again after low
    step(1'b0, 1'b0, 16'h6666, "R8");
    step(1'b0, 1'b1, 16'h6667, "R4");
    // R6: release, then reload
    step(1'b1, 1'b1, 16'h7777, "R6");
    step(1'b0, 1'b1, 16'h8888, "R6");
    step(1'b0, 1'b0, 16'h9999, "R1");
    step(1'b0, 1'b1, 16'hAAAA, "R3");
    // R10: reset in the middle of a read
    @(posedge clk); #2 rst_n = 1'b0;
    step(1'b0, 1'b0, 16'hF0F0, "R10");
    step(1'b0, 1'b1, 16'hF1F1, "R10");
    @(posedge clk); #2 rst_n = 1'b1; oe_n = 1'b1;
    step(1'b0, 1'b1, 16'h4321, "R10");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic o, s;
      o = ($urandom % 3) == 0;
      s = $urandom % 2;
      step(o, s, 16'($urandom), "");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule